// File: doc/BRIEF.md
# Parallel Port Peripheral Handshake Responder

This block sits on the peripheral end of an enhanced-mode parallel port link and answers every host cycle in hardware. When the host writes a byte, the responder captures it as the strobe becomes active and tags it as data or address, depending on which strobe was used. It then offers the byte to a local consumer over a valid/ready pair. The wait line tells the host whether the responder is ready or busy. Each strobe is acknowledged by raising wait, and wait stays busy while an unread byte sits in the one-entry receive buffer, so no host write is lost.

For uploads, the local side hands over a byte. The responder holds it, pulls the interrupt line low to request service, and drives the byte onto the bus whenever the host has set the direction line to read. The request clears when the host finishes a data read cycle. A host address read returns the most recently received address byte.

A separate status pin reports receive errors to the host (low means error) so that the host can resend. The cable inverts the write, strobe and wait signals, so a parameter chooses the polarity used at these pins.

Top module: `epp_responder`

## Requirements
- R1: After reset, wait shows ready, the interrupt pin is high, the error pin is high, the bus is not driven, rx_valid_o is 0 and tx_ready_o is 1.
- R2: A host write with the data strobe stores the bus byte and presents it on rx_data_o with rx_valid_o high and rx_is_addr_o = 0.
- R3: A host write with the address strobe presents the byte with rx_is_addr_o = 1.
- R4: Wait turns busy after a strobe becomes active and stays busy while the strobe is held.
- R5: While the receive buffer holds an unconsumed byte, wait stays busy. It returns to ready once the consumer takes the byte (rx_valid_o and rx_ready_i high at a clock edge) and no strobe is active.
- R6: A host write strobe that arrives while the buffer is full is discarded, and the buffered byte and tag are unchanged.
- R7: pp_data_oe_o is 0 whenever the direction line says the host is writing.
- R8: A byte offered with tx_valid_i while tx_ready_o is 1 is accepted. The interrupt pin then goes low and tx_ready_o stays 0 until the byte has been read.
- R9: While the host reads with the data strobe, pp_data_o carries the pending upload byte with pp_data_oe_o = 1. After the strobe is released, the interrupt pin returns high and tx_ready_o returns to 1.
- R10: A host read with the address strobe returns the last byte received through an address write.
- R11: The error pin goes low one clock after rx_err_i is high, and goes high again one clock after rx_err_i is low.
- R12: With PIN_INVERT = 1, the write, both strobes and wait are active-high at the pins (wait pin 1 = ready). With PIN_INVERT = 0, they are active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pp_data_i | input | DATA_W | Byte from the port bus |
| pp_data_o | output | DATA_W | Byte driven to the port bus |
| pp_data_oe_o | output | 1 | Bus drive enable |
| pp_write_i | input | 1 | Host direction line (polarity per PIN_INVERT) |
| pp_dstb_i | input | 1 | Host data strobe (polarity per PIN_INVERT) |
| pp_astb_i | input | 1 | Host address strobe (polarity per PIN_INVERT) |
| pp_wait_o | output | 1 | Ready/busy handshake to host (polarity per PIN_INVERT) |
| pp_intr_o | output | 1 | Upload request, low = pending |
| pp_err_o | output | 1 | Receive error status, low = error |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| rx_data_o | output | DATA_W | Received byte |
| rx_is_addr_o | output | 1 | Received byte came from an address strobe |
| tx_valid_i | input | 1 | Local side offers an upload byte |
| tx_ready_o | output | 1 | Upload slot free |
| tx_data_i | input | DATA_W | Upload byte |
| rx_err_i | input | 1 | Local receive error flag |

## Verification
The bench builds the responder with PIN_INVERT = 1 and SYNC_STAGES = 3. This puts the inverted-cable pin polarity and a deeper synchronizer than the default under test, so every handshake is exercised with a longer strobe-to-wait delay. Overrun writes that ignore wait reach the discard path. Interleaved uploads and address reads show that the pending byte and the last address byte stay separate.

// File: rtl/epp_pkg.sv
`timescale 1ns/1ps
package epp_pkg;
  typedef enum logic {TAG_DATA = 1'b0, TAG_ADDR = 1'b1} tag_e;
  typedef struct packed {
    logic wr;    // host writing
    logic astb;  // address strobe active
    logic dstb;  // data strobe active
  } ctrl_t;
endpackage

// File: rtl/epp_sync.sv
`timescale 1ns/1ps
module epp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[k] <= '0;
      else if (k == 0) st[k] <= d_i;
      else st[k] <= st[(k == 0) ? 0 : k-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/epp_rx.sv
`timescale 1ns/1ps
module epp_rx
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  tag_e              tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output tag_e              tag_o,
  output logic [DATA_W-1:0] addr_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q, addr_q;
  tag_e              tag_q;
  logic              accept, pop;

  assign accept = cap_i & ~full_q;  // writes into a full slot are dropped
  assign pop    = full_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      tag_q  <= TAG_DATA;
      addr_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= data_i;
      tag_q  <= tag_i;
      if (tag_i == TAG_ADDR) addr_q <= data_i;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  assign valid_o = full_q;
  assign data_o  = data_q;
  assign tag_o   = tag_q;
  assign addr_o  = addr_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !ready_i |=> full_q && $stable(data_q) && $stable(tag_q)); // R6
endmodule

// File: rtl/epp_tx.sv
`timescale 1ns/1ps
module epp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hold_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  // no load during an active strobe: the closing edge must not clear an unseen byte
  assign ready_o = ~pend_q & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (load_i && ready_o) begin
      pend_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign data_o = data_q;

  AST_LOAD_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ready_o |=> pend_q); // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !take_i |=> pend_q && $stable(data_q)); // R8
endmodule

// File: rtl/epp_responder.sv
`timescale 1ns/1ps
module epp_responder
  import epp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit PIN_INVERT  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pp_data_i,
  output logic [DATA_W-1:0] pp_data_o,
  output logic              pp_data_oe_o,
  input  logic              pp_write_i,
  input  logic              pp_dstb_i,
  input  logic              pp_astb_i,
  output logic              pp_wait_o,
  output logic              pp_intr_o,
  output logic              pp_err_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_is_addr_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_err_i
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctl_a, ctl_s;
  logic              strb_s, strb_q, rise, fall;
  logic              rd_cyc_q, adr_cyc_q, busy_q, err_q;
  logic              rx_full, tx_pend;
  logic [DATA_W-1:0] addr_last, tx_byte;
  tag_e              rx_tag, cap_tag;

  // pin polarity to logical "active"
  if (PIN_INVERT) begin : g_pin_inv
    assign ctl_a     = '{wr: pp_write_i, astb: pp_astb_i, dstb: pp_dstb_i};
    assign pp_wait_o = ~busy_q;
  end else begin : g_pin_dir
    assign ctl_a     = '{wr: ~pp_write_i, astb: ~pp_astb_i, dstb: ~pp_dstb_i};
    assign pp_wait_o = busy_q;
  end

  epp_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(ctl_a), .q_o(ctl_s)
  );

  assign strb_s  = ctl_s.dstb | ctl_s.astb;
  assign rise    = strb_s & ~strb_q;
  assign fall    = ~strb_s & strb_q;
  assign cap_tag = ctl_s.astb ? TAG_ADDR : TAG_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q    <= 1'b0;
      rd_cyc_q  <= 1'b0;
      adr_cyc_q <= 1'b0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      strb_q <= strb_s;
      if (rise) begin
        rd_cyc_q  <= ~ctl_s.wr;
        adr_cyc_q <= ctl_s.astb;
      end
      busy_q <= strb_s | rx_full;
      err_q  <= rx_err_i;
    end
  end

  epp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .cap_i   (rise & ctl_s.wr),
    .tag_i   (cap_tag),
    .data_i  (pp_data_i),
    .ready_i (rx_ready_i),
    .valid_o (rx_full),
    .data_o  (rx_data_o),
    .tag_o   (rx_tag),
    .addr_o  (addr_last)
  );

  epp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .hold_i  (strb_s),
    .take_i  (fall & rd_cyc_q & ~adr_cyc_q),
    .ready_o (tx_ready_o),
    .pend_o  (tx_pend),
    .data_o  (tx_byte)
  );

  assign rx_valid_o   = rx_full;
  assign rx_is_addr_o = (rx_tag == TAG_ADDR);
  assign pp_data_oe_o = ~ctl_s.wr & (strb_s | tx_pend);
  assign pp_data_o    = ctl_s.astb ? addr_last : tx_byte;
  assign pp_intr_o    = ~tx_pend;
  assign pp_err_o     = ~err_q;

  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_s && strb_q |-> busy_q); // R4
  AST_BUSY_WHILE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> busy_q); // R5
  AST_ERR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_i |=> !pp_err_o); // R11
endmodule

// File: tb/sim_epp_responder.sv
`timescale 1ns/1ps
module sim_epp_responder;
  localparam int  DW   = 8;
  localparam int  SYNC = 3;
  localparam bit  PINV = 1'b1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] pp_data_i = '0, pp_data_o, rx_data, tx_data = '0;
  logic          pp_oe, pp_write, pp_dstb, pp_astb, pp_wait, pp_intr, pp_err;
  logic          rx_valid, rx_ready = 1'b0, rx_is_addr, tx_valid = 1'b0, tx_ready, rx_err = 1'b0;

  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] exp_addr = '0;

  always #4 clk = ~clk;

  epp_responder #(.DATA_W(DW), .SYNC_STAGES(SYNC), .PIN_INVERT(PINV)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pp_data_i(pp_data_i), .pp_data_o(pp_data_o), .pp_data_oe_o(pp_oe),
    .pp_write_i(pp_write), .pp_dstb_i(pp_dstb), .pp_astb_i(pp_astb),
    .pp_wait_o(pp_wait), .pp_intr_o(pp_intr), .pp_err_o(pp_err),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data), .rx_is_addr_o(rx_is_addr),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data), .rx_err_i(rx_err)
  );

  // R12: logical active level to pin level and back
  function automatic logic to_pin(input logic act);
    return PINV ? act : ~act;
  endfunction
  function automatic logic busy_now();
    return PINV ? ~pp_wait : pp_wait;
  endfunction

  initial begin
    pp_write = to_pin(1'b0);
    pp_dstb  = to_pin(1'b0);
    pp_astb  = to_pin(1'b0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(input logic want, input string req);
    for (int i = 0; i < 60; i++) begin
      if (busy_now() == want) return;
      @(negedge clk);
    end
    check(req, busy_now(), want);
  endtask

  task automatic host_write(input logic is_addr, input logic [DW-1:0] b, input logic honor);
    @(negedge clk);
    pp_write  = to_pin(1'b1);
    pp_data_i = b;
    repeat (SYNC + 1) @(negedge clk);
    if (honor) wait_busy(1'b0, "R5");
    if (is_addr) pp_astb = to_pin(1'b1); else pp_dstb = to_pin(1'b1);
    wait_busy(1'b1, "R4");
    repeat (3) @(negedge clk);
    check("R4 busy while strobe held", busy_now(), 1'b1);
    check("R7 no drive in write", pp_oe, 1'b0);
    pp_dstb = to_pin(1'b0);
    pp_astb = to_pin(1'b0);
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic host_read(input logic is_addr, output logic [DW-1:0] b);
    @(negedge clk);
    pp_write = to_pin(1'b0);
    repeat (SYNC + 2) @(negedge clk);
    wait_busy(1'b0, "R4");
    if (is_addr) pp_astb = to_pin(1'b1); else pp_dstb = to_pin(1'b1);
    wait_busy(1'b1, "R4");
    repeat (2) @(negedge clk);
    check("R9 drive in read", pp_oe, 1'b1);
    b = pp_data_o;
    pp_dstb = to_pin(1'b0);
    pp_astb = to_pin(1'b0);
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic upload(input logic [DW-1:0] b);
    @(negedge clk);
    check("R8 slot free", tx_ready, 1'b1);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R8 intr low", pp_intr, 1'b0);
    check("R8 slot busy", tx_ready, 1'b0);
  endtask

  initial begin
    logic [DW-1:0] got, b;
    int seed_init;
    seed_init = $urandom(32'd1284);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R12: inverted pins, wait pin 1 means ready
    check("R1 R12 wait pin ready", pp_wait, 1'b1);
    check("R1 intr", pp_intr, 1'b1);
    check("R1 err", pp_err, 1'b1);
    check("R1 oe", pp_oe, 1'b0);
    check("R1 rx_valid", rx_valid, 1'b0);
    check("R1 tx_ready", tx_ready, 1'b1);

    host_write(1'b0, 8'hA5, 1'b1);
    check("R2 valid", rx_valid, 1'b1);
    check("R2 data", rx_data, 8'hA5);
    check("R2 tag", rx_is_addr, 1'b0);
    check("R5 busy while full", busy_now(), 1'b1);

    host_write(1'b1, 8'h3C, 1'b0);  // overrun, ignores wait
    check("R6 data kept", rx_data, 8'hA5);
    check("R6 tag kept", rx_is_addr, 1'b0);
    pop();
    repeat (2) @(negedge clk);
    check("R5 ready after take", busy_now(), 1'b0);
    check("R5 empty", rx_valid, 1'b0);

    host_write(1'b1, 8'h5A, 1'b1);
    exp_addr = 8'h5A;
    check("R3 tag", rx_is_addr, 1'b1);
    check("R3 data", rx_data, 8'h5A);
    pop();

    upload(8'h96);
    host_read(1'b0, got);
    check("R9 byte", got, 8'h96);
    check("R9 intr cleared", pp_intr, 1'b1);
    check("R9 slot free", tx_ready, 1'b1);

    host_read(1'b1, got);
    check("R10 addr read", got, exp_addr);

    @(negedge clk) rx_err = 1'b1;
    @(negedge clk);
    check("R11 err low", pp_err, 1'b0);
    rx_err = 1'b0;
    @(negedge clk);
    check("R11 err high", pp_err, 1'b1);

    for (int it = 0; it < 30; it++) begin
      int op;
      op = $urandom % 4;
      b  = DW'($urandom);
      if (op < 2) begin
        host_write(op[0], b, 1'b1);
        check("R2 R3 rand data", rx_data, b);
        check("R2 R3 rand tag", rx_is_addr, op[0]);
        if (op == 1) exp_addr = b;
        repeat ($urandom % 4) @(negedge clk);
        check("R5 rand busy", busy_now(), 1'b1);
        pop();
        repeat (2) @(negedge clk);
        check("R5 rand ready", busy_now(), 1'b0);
      end else if (op == 2) begin
        upload(b);
        host_read(1'b0, got);
        check("R9 rand byte", got, b);
        check("R9 rand intr", pp_intr, 1'b1);
      end else begin
        host_read(1'b1, got);
        check("R10 rand addr", got, exp_addr);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule